// File: doc/BRIEF.md
# Read-Address Sequence Command Decoder

This block sits beside a byte-wide memory and turns a fixed series of ordinary read accesses into control commands. The bus logic ahead of it presents one pulse for every completed read and one for every completed write, with the address valid during the pulse. The reads complete as normal memory reads. The decoder only tracks them, and it issues a command when a read ends a valid series.

A valid series has six reads. The first five reads go to one fixed list of addresses, in a fixed order. The sixth read goes to one of four addresses, and that address selects the command: store to nonvolatile cells, recall from them, turn automatic power-down storing off, or turn it on. Only the low sixteen address bits are compared. A write anywhere in the series cancels it. A read from any other address also cancels it, except a read of the first prefix address, which starts a new series at once. A read may come from a chip-enable or an output-enable access, because the bus logic turns both into the same read pulse.

Top module: `addr_seq_cmd`

## Requirements
- R1: While reset is held, and in the first cycle after it, all four command outputs are low.
- R2: A series is five reads at low addresses 0x4E38, 0xB1C7, 0x83E0, 0x7C1F, 0x703F in that order, then a sixth command read. The command output goes high for exactly the one cycle that follows the clock edge sampling the sixth read pulse.
- R3: The sixth address selects the command: 0x8FC0 gives cmdStore, 0x4C63 gives cmdRecall, 0x8B45 gives cmdAutoOff, and 0x4B46 gives cmdAutoOn.
- R4: Address bit 16 is ignored at every step. A series with that bit set behaves the same as one with it clear.
- R5: At most one command output is high in any cycle. A command pulse is always followed by a low cycle.
- R6: A write pulse at any step aborts the series and no command is issued. A write in the same cycle as a read counts as an abort.
- R7: During the five prefix steps, a read from an address that is not the expected one aborts the series and returns the decoder to idle.
- R8: A mismatching prefix-step read from low address 0x4E38 counts as step one of a new series.
- R9: After any sixth read, the decoder returns to idle, whether or not the address was one of the four command codes. An unknown sixth address issues no command.
- R10: Cycles with no read or write pulse leave the progress through the series unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rdStrobe | input | 1 | One-cycle pulse per completed read |
| wrStrobe | input | 1 | One-cycle pulse per completed write |
| addr | input | 17 | Address of the access in the strobe cycle |
| cmdStore | output | 1 | Store command pulse |
| cmdRecall | output | 1 | Recall command pulse |
| cmdAutoOff | output | 1 | Disable automatic store pulse |
| cmdAutoOn | output | 1 | Enable automatic store pulse |

## Verification
A vector table runs each of the four complete series with no gaps, which shows that each final code drives the right output and no other. Directed series then add idle gaps, set the ignored top bit, and put a write in the middle and a write at the final step. The write cases separate an abort on a write from one that needs a read. A series broken by a wrong address, one broken by a repeated 0x4E38, and a series with an unknown sixth address show the difference between a return to idle and a restart at step one. A lone final-code read after an unknown sixth address confirms that the decoder really reached idle.

// File: rtl/seq_cmd_pkg.sv
package seq_cmd_pkg;
  localparam int CMP_W = 16;
  localparam int PREFIX_LEN = 5;
  localparam int NUM_CMDS = 4;

  // command index order: 0 store, 1 recall, 2 auto off, 3 auto on
  localparam int CMD_STORE = 0;
  localparam int CMD_RECALL = 1;
  localparam int CMD_AUTO_OFF = 2;
  localparam int CMD_AUTO_ON = 3;

  typedef struct packed {
    logic advance;  // step matched, move forward
    logic restart;  // re-enter at step one
    logic clear;    // back to idle
    logic fire;     // final step, launch selected command
  } ctlStb_t;

  function automatic logic [CMP_W-1:0] prefixCode(input int idx);
    case (idx)
      0: prefixCode = 16'h4E38;
      1: prefixCode = 16'hB1C7;
      2: prefixCode = 16'h83E0;
      3: prefixCode = 16'h7C1F;
      4: prefixCode = 16'h703F;
      default: prefixCode = '0;
    endcase
  endfunction

  function automatic logic [CMP_W-1:0] finalCode(input int idx);
    case (idx)
      CMD_STORE: finalCode = 16'h8FC0;
      CMD_RECALL: finalCode = 16'h4C63;
      CMD_AUTO_OFF: finalCode = 16'h8B45;
      CMD_AUTO_ON: finalCode = 16'h4B46;
      default: finalCode = '0;
    endcase
  endfunction
endpackage

// File: rtl/seq_match_dp.sv
module seq_match_dp
  import seq_cmd_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int STEP_W = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [STEP_W-1:0]   step,
  input  ctlStb_t             stb,
  output logic                prefixHit,
  output logic                startHit,
  output logic [NUM_CMDS-1:0] cmdOut
);
  logic [CMP_W-1:0] lowAddr;
  logic [PREFIX_LEN-1:0] hitVec;
  logic [NUM_CMDS-1:0] finalHit;

  assign lowAddr = addr[CMP_W-1:0];

  for (genvar i = 0; i < PREFIX_LEN; i++) begin : g_prefix
    assign hitVec[i] = (lowAddr == prefixCode(i));
  end

  for (genvar j = 0; j < NUM_CMDS; j++) begin : g_final
    assign finalHit[j] = (lowAddr == finalCode(j));
  end

  always_comb begin
    prefixHit = 1'b0;
    for (int k = 0; k < PREFIX_LEN; k++) begin
      if (step == STEP_W'(k) && hitVec[k]) prefixHit = 1'b1;
    end
  end

  assign startHit = hitVec[0];

  always_ff @(posedge clk) begin
    if (!rstN) cmdOut <= '0;
    else if (stb.fire) cmdOut <= finalHit;
    else cmdOut <= '0;
  end
endmodule

// File: rtl/seq_match_ctl.sv
module seq_match_ctl
  import seq_cmd_pkg::*;
#(
  parameter int STEP_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rdStrobe,
  input  logic              wrStrobe,
  input  logic              prefixHit,
  input  logic              startHit,
  output logic [STEP_W-1:0] step,
  output ctlStb_t           stb
);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(PREFIX_LEN);

  always_comb begin
    stb = '0;
    if (wrStrobe) begin
      stb.clear = 1'b1;
    end else if (rdStrobe) begin
      if (step == LAST_STEP) begin
        stb.fire = 1'b1;
        stb.clear = 1'b1;
      end else if (prefixHit) begin
        stb.advance = 1'b1;
      end else if (startHit) begin
        stb.restart = 1'b1;
      end else begin
        stb.clear = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) step <= '0;
    else if (stb.clear) step <= '0;
    else if (stb.restart) step <= STEP_W'(1);
    else if (stb.advance) step <= step + STEP_W'(1);
  end
endmodule

// File: rtl/addr_seq_cmd.sv
module addr_seq_cmd
  import seq_cmd_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rdStrobe,
  input  logic              wrStrobe,
  input  logic [ADDR_W-1:0] addr,
  output logic              cmdStore,
  output logic              cmdRecall,
  output logic              cmdAutoOff,
  output logic              cmdAutoOn
);
  localparam int STEP_W = $clog2(PREFIX_LEN + 1);

  logic [STEP_W-1:0] step;
  ctlStb_t stb;
  logic prefixHit;
  logic startHit;
  logic [NUM_CMDS-1:0] cmdOut;

  seq_match_ctl #(.STEP_W(STEP_W)) u_ctl (
    .clk(clk), .rstN(rstN), .rdStrobe(rdStrobe), .wrStrobe(wrStrobe),
    .prefixHit(prefixHit), .startHit(startHit), .step(step), .stb(stb)
  );

  seq_match_dp #(.ADDR_W(ADDR_W), .STEP_W(STEP_W)) u_dp (
    .clk(clk), .rstN(rstN), .addr(addr), .step(step), .stb(stb),
    .prefixHit(prefixHit), .startHit(startHit), .cmdOut(cmdOut)
  );

  assign cmdStore = cmdOut[CMD_STORE];
  assign cmdRecall = cmdOut[CMD_RECALL];
  assign cmdAutoOff = cmdOut[CMD_AUTO_OFF];
  assign cmdAutoOn = cmdOut[CMD_AUTO_ON];
endmodule

// File: rtl/addr_seq_cmd_chk.sv
module addr_seq_cmd_chk #(
  parameter int ADDR_W = 17
) (
  input logic              clk,
  input logic              rstN,
  input logic              rdStrobe,
  input logic              wrStrobe,
  input logic [ADDR_W-1:0] addr,
  input logic              cmdStore,
  input logic              cmdRecall,
  input logic              cmdAutoOff,
  input logic              cmdAutoOn
);
  logic [3:0] cmds;
  assign cmds = {cmdAutoOn, cmdAutoOff, cmdRecall, cmdStore};

  // R5: never more than one command at a time
  a_r5_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(cmds));

  // R5: a pulse lasts one cycle
  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    (cmds != 4'b0) |=> (cmds == 4'b0));

  // R6: a write cycle never yields a command
  a_r6_write_blocks: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe |=> (cmds == 4'b0));

  // R10: no command without a read in the prior cycle
  a_r10_no_read_no_cmd: assert property (@(posedge clk) disable iff (!rstN)
    !rdStrobe |=> (cmds == 4'b0));

  // R1: outputs quiet in the first cycle after reset
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rstN |=> (cmds == 4'b0));
endmodule

bind addr_seq_cmd addr_seq_cmd_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .rdStrobe(rdStrobe), .wrStrobe(wrStrobe),
  .addr(addr), .cmdStore(cmdStore), .cmdRecall(cmdRecall),
  .cmdAutoOff(cmdAutoOff), .cmdAutoOn(cmdAutoOn)
);

// File: tb/sim_addr_seq_cmd.sv
module sim_addr_seq_cmd;
  localparam int CLK_PERIOD = 10;
  localparam logic [1:0] K_IDLE = 2'd0, K_RD = 2'd1, K_WR = 2'd2, K_BOTH = 2'd3;
  // expected bits: {autoOn, autoOff, recall, store}
  localparam logic [3:0] E0 = 4'b0000, ES = 4'b0001, ER = 4'b0010,
                         EOFF = 4'b0100, EON = 4'b1000;
  localparam int NV = 24;
  // entry: {kind[1:0], addr[16:0], expect[3:0]}
  localparam logic [22:0] VEC [NV] = '{
    {K_RD, 17'h04E38, E0}, {K_RD, 17'h0B1C7, E0}, {K_RD, 17'h083E0, E0},
    {K_RD, 17'h07C1F, E0}, {K_RD, 17'h0703F, E0}, {K_RD, 17'h08FC0, ES},
    {K_RD, 17'h04E38, E0}, {K_RD, 17'h0B1C7, E0}, {K_RD, 17'h083E0, E0},
    {K_RD, 17'h07C1F, E0}, {K_RD, 17'h0703F, E0}, {K_RD, 17'h04C63, ER},
    {K_RD, 17'h04E38, E0}, {K_RD, 17'h0B1C7, E0}, {K_RD, 17'h083E0, E0},
    {K_RD, 17'h07C1F, E0}, {K_RD, 17'h0703F, E0}, {K_RD, 17'h08B45, EOFF},
    {K_RD, 17'h04E38, E0}, {K_RD, 17'h0B1C7, E0}, {K_RD, 17'h083E0, E0},
    {K_RD, 17'h07C1F, E0}, {K_RD, 17'h0703F, E0}, {K_RD, 17'h04B46, EON}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rdStrobe = 1'b0;
  logic wrStrobe = 1'b0;
  logic [16:0] addr = '0;
  logic cmdStore, cmdRecall, cmdAutoOff, cmdAutoOn;
  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  addr_seq_cmd u0 (
    .clk(clk), .rstN(rstN), .rdStrobe(rdStrobe), .wrStrobe(wrStrobe),
    .addr(addr), .cmdStore(cmdStore), .cmdRecall(cmdRecall),
    .cmdAutoOff(cmdAutoOff), .cmdAutoOn(cmdAutoOn)
  );

  function automatic logic [3:0] outs();
    return {cmdAutoOn, cmdAutoOff, cmdRecall, cmdStore};
  endfunction

  task automatic check(input logic [3:0] exp, input string req);
    checks++;
    if (outs() !== exp) begin
      failures++;
      $display("FAIL %s: cmds actual=%b expected=%b", req, outs(), exp);
    end
  endtask

  // drive at a falling edge, check after the next falling edge
  task automatic op(input logic [1:0] kind, input logic [16:0] a,
                    input logic [3:0] exp, input string req);
    rdStrobe = kind[0];
    wrStrobe = kind[1];
    addr = a;
    @(negedge clk);
    check(exp, req);
  endtask

  task automatic prefix(input logic hi, input int upto, input string req);
    logic [15:0] p [5] = '{16'h4E38, 16'hB1C7, 16'h83E0, 16'h7C1F, 16'h703F};
    for (int i = 0; i < upto; i++) op(K_RD, {hi, p[i]}, E0, req);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(E0, "R1 during reset");
    rstN = 1'b1;
    @(negedge clk);
    check(E0, "R1 after reset");

    // R3 table of the four full series
    for (int v = 0; v < NV; v++) begin
      op(VEC[v][22:21], VEC[v][20:4], VEC[v][3:0], "R3 table");
    end
    op(K_IDLE, '0, E0, "R5 pulse ends");

    // R2 timing with R10 idle gaps between steps
    for (int i = 0; i < 5; i++) begin
      logic [15:0] p [5] = '{16'h4E38, 16'hB1C7, 16'h83E0, 16'h7C1F, 16'h703F};
      op(K_RD, {1'b0, p[i]}, E0, "R10 gap");
      op(K_IDLE, 17'h08FC0, E0, "R10 gap idle");
      op(K_IDLE, '0, E0, "R10 gap idle");
    end
    op(K_RD, 17'h08FC0, ES, "R2 store after gaps");
    op(K_IDLE, '0, E0, "R2 one-cycle pulse");

    // R4 top bit set everywhere
    prefix(1'b1, 5, "R4 prefix");
    op(K_RD, 17'h14C63, ER, "R4 recall with bit16");

    // R6 write mid-series
    prefix(1'b0, 3, "R6 prefix");
    op(K_WR, 17'h07C1F, E0, "R6 write");
    op(K_RD, 17'h07C1F, E0, "R6 after write");
    op(K_RD, 17'h0703F, E0, "R6 after write");
    op(K_RD, 17'h08FC0, E0, "R6 no store");
    // R6 read and write together at the final step
    prefix(1'b0, 5, "R6 prefix");
    op(K_BOTH, 17'h08FC0, E0, "R6 combined final");
    op(K_RD, 17'h08FC0, E0, "R6 idle after combined");

    // R7 wrong address mid-series
    prefix(1'b0, 2, "R7 prefix");
    op(K_RD, 17'h00000, E0, "R7 mismatch");
    op(K_RD, 17'h083E0, E0, "R7 resume");
    op(K_RD, 17'h07C1F, E0, "R7 resume");
    op(K_RD, 17'h0703F, E0, "R7 resume");
    op(K_RD, 17'h04C63, E0, "R7 no recall");

    // R8 restart on repeated first address
    prefix(1'b0, 3, "R8 prefix");
    op(K_RD, 17'h04E38, E0, "R8 restart");
    op(K_RD, 17'h0B1C7, E0, "R8 continue");
    op(K_RD, 17'h083E0, E0, "R8 continue");
    op(K_RD, 17'h07C1F, E0, "R8 continue");
    op(K_RD, 17'h0703F, E0, "R8 continue");
    op(K_RD, 17'h08B45, EOFF, "R8 auto off");

    // R9 unknown sixth address, then idle
    prefix(1'b0, 5, "R9 prefix");
    op(K_RD, 17'h01234, E0, "R9 unknown sixth");
    op(K_RD, 17'h04B46, E0, "R9 idle after sixth");
    // R9 sixth equal to first prefix address goes to idle, not step one
    prefix(1'b0, 5, "R9 prefix");
    op(K_RD, 17'h04E38, E0, "R9 sixth is 4E38");
    op(K_RD, 17'h0B1C7, E0, "R9 idle");
    op(K_RD, 17'h083E0, E0, "R9 idle");
    op(K_RD, 17'h07C1F, E0, "R9 idle");
    op(K_RD, 17'h0703F, E0, "R9 idle");
    op(K_RD, 17'h08FC0, E0, "R9 no store");

    // R1 reset mid-series discards progress
    prefix(1'b0, 5, "R1 prefix");
    rstN = 1'b0;
    op(K_IDLE, '0, E0, "R1 reset");
    rstN = 1'b1;
    op(K_RD, 17'h08FC0, E0, "R1 progress cleared");

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule